// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block models a byte-wide working memory in which every word has a nonvolatile shadow word behind it. The host sees an ordinary static RAM interface, sampled on the system clock. It has an active-low chip enable, output enable and write enable, a 13-bit address, and an 8-bit data bus that is split into an input, an output and an output-enable.

Ordinary reads and writes reach only the working array. A bulk copy from the working array to the shadow array (STORE), or from the shadow array back (RECALL), starts only when the host issues a fixed run of six read accesses with nothing in between. A RECALL also runs by itself each time reset is released. While either transfer runs, a busy output is high and the host is locked out completely.

A RECALL first clears the working array and then loads the shadow contents into it. Both durations are parameters given in clock cycles.

Top module: `nv_shadow_sram`

## Requirements
- R1: An access begins on a clock where ceN is low after a clock where it was high. A write stores dqIn at every clock with ceN and weN low and busy low. A read clock (ceN low, oeN low, weN high) presents the addressed word on dqOut with dqOutEn high one clock later. The array index is the address modulo DEPTH (default 2048), so 0x0805 and 0x0005 name the same word.
- R2: After reset is released, busy stays high for exactly RECALL_CYC clocks, counting the clock of release. During that time dqOutEn is low.
- R3: Six consecutive read accesses to 0x0E38, 0x11C7, 0x03E0, 0x1C1F, 0x103F and 0x0FC0 start a STORE. busy rises on the clock after the sixth access and stays high for exactly STORE_CYC clocks. The shadow array then holds a copy of the working array.
- R4: The same run of six read accesses, but ending in 0x0C63, starts a RECALL that is busy for RECALL_CYC clocks. Afterwards every working word equals its shadow word, and writes made since the last STORE are lost.
- R5: A write access inside the run, or a read access to an address that is not the next one expected, abandons the run. Completing the remaining addresses then starts no transfer.
- R6: Clocks with ceN high neither advance nor abandon the run, and they write nothing, whatever weN, address and dqIn do.
- R7: While busy is high, dqOutEn is low and write accesses leave the working array unchanged.
- R8: Neither ordinary writes nor a RECALL change the shadow array. Repeated RECALLs return the same data.
- R9: dqOutEn is high only on the clock after a read clock made with oeN low. A read with oeN high leaves dqOutEn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset; release triggers a RECALL |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 13 | Word address |
| dqIn | input | 8 | Write data |
| dqOut | output | 8 | Read data |
| dqOutEn | output | 1 | High when dqOut is driven; low means high-impedance |
| busy | output | 1 | High during a STORE or RECALL |

## Verification
The checks on transfer length and on transfer start assume that the host pulses ceN, with at least one high clock between accesses, so that each access is seen once. They also assume that a transfer can only follow a read made with ceN low. The stimulus raises ceN for at least one clock after every access, and it changes its inputs only on falling edges, so every input is stable at the sampling edge. Pauses with ceN high are inserted in the middle of a command run on purpose, to show that those clocks are neither counted nor treated as writes.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t STORE_KEY  = 13'h0FC0;
  localparam addr_t RECALL_KEY = 13'h0C63;

  // control -> datapath strobes
  typedef struct packed {
    logic copyToShadow;
    logic clearWork;
    logic loadWork;
    logic busy;
  } nvStrobe_t;

  // expected address for each of the five leading command steps
  function automatic addr_t keyAddr(input logic [2:0] step);
    case (step)
      3'd0:    keyAddr = 13'h0E38;
      3'd1:    keyAddr = 13'h11C7;
      3'd2:    keyAddr = 13'h03E0;
      3'd3:    keyAddr = 13'h1C1F;
      default: keyAddr = 13'h103F;
    endcase
  endfunction
endpackage

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int STORE_CYC  = 20,
  parameter int RECALL_CYC = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      weN,
  input  addr_t     addr,
  output nvStrobe_t strobe
);
  localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int LAST_STEP = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_RECALL} ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       step;
  logic             ceNPrev;
  logic             accessStart;
  logic             stepHit;
  logic             restartHit;

  assign accessStart = !ceN && ceNPrev;
  assign stepHit     = (addr == keyAddr(step));
  assign restartHit  = (addr == keyAddr(3'd0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RECALL;
      cnt     <= '0;
      step    <= '0;
      ceNPrev <= 1'b1;
    end else begin
      ceNPrev <= ceN;
      case (state)
        ST_IDLE: begin
          if (accessStart) begin
            if (!weN) begin
              step <= '0;
            end else if (step == 3'(LAST_STEP)) begin
              if (addr == STORE_KEY) begin
                state <= ST_STORE;
                cnt   <= '0;
                step  <= '0;
              end else if (addr == RECALL_KEY) begin
                state <= ST_RECALL;
                cnt   <= '0;
                step  <= '0;
              end else begin
                step <= restartHit ? 3'd1 : 3'd0;
              end
            end else if (stepHit) begin
              step <= step + 3'd1;
            end else begin
              step <= restartHit ? 3'd1 : 3'd0;
            end
          end
        end
        ST_STORE: begin
          step <= '0;
          if (cnt == CNT_W'(STORE_CYC - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          step <= '0;
          if (cnt == CNT_W'(RECALL_CYC - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.busy         = (state != ST_IDLE);
    strobe.copyToShadow = (state == ST_STORE) && (cnt == '0);
    strobe.clearWork    = (state == ST_RECALL) && (cnt == '0);
    strobe.loadWork     = (state == ST_RECALL) && (cnt == CNT_W'(RECALL_CYC - 1));
  end
endmodule

// File: rtl/nvs_datapath.sv
module nvs_datapath
  import nvs_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvStrobe_t         strobe,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  addr_t             addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOutEn
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] workArr   [DEPTH];
  logic [DATA_W-1:0] shadowArr [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;

  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (strobe.copyToShadow) begin
      shadowArr <= workArr;
    end
  end

  // RECALL phase one clears, phase two loads; host writes only when idle
  always_ff @(posedge clk) begin
    if (strobe.clearWork) begin
      workArr <= '{default: '0};
    end else if (strobe.loadWork) begin
      workArr <= shadowArr;
    end else if (!strobe.busy && !ceN && !weN) begin
      workArr[idx] <= dqIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
    end else begin
      rdValid <= !ceN && !oeN && weN && !strobe.busy;
    end
  end

  always_ff @(posedge clk) begin
    rdData <= workArr[idx];
  end

  assign dqOut   = rdData;
  assign dqOutEn = rdValid && !strobe.busy;
endmodule

// File: rtl/nv_shadow_sram.sv
module nv_shadow_sram
  import nvs_pkg::*;
#(
  parameter int DEPTH      = 2048,
  parameter int STORE_CYC  = 20,
  parameter int RECALL_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOutEn,
  output logic              busy
);
  nvStrobe_t strobe;

  nvs_ctrl #(
    .STORE_CYC (STORE_CYC),
    .RECALL_CYC(RECALL_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ceN   (ceN),
    .weN   (weN),
    .addr  (addr),
    .strobe(strobe)
  );

  nvs_datapath #(
    .DEPTH(DEPTH)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .ceN    (ceN),
    .oeN    (oeN),
    .weN    (weN),
    .addr   (addr),
    .dqIn   (dqIn),
    .dqOut  (dqOut),
    .dqOutEn(dqOutEn)
  );

  assign busy = strobe.busy;
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
  parameter int STORE_CYC  = 20,
  parameter int RECALL_CYC = 8
) (
  input logic clk,
  input logic rstN,
  input logic ceN,
  input logic oeN,
  input logic weN,
  input logic busy,
  input logic dqOutEn
);
  int runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= 0;
  end

  // R7
  busy_bus_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !dqOutEn);

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOutEn |-> $past(!oeN && !ceN && weN));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!ceN && weN));

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == STORE_CYC || runLen == RECALL_CYC));
endmodule

bind nv_shadow_sram nvs_chk #(
  .STORE_CYC (STORE_CYC),
  .RECALL_CYC(RECALL_CYC)
) u_chk (.*);

// File: tb/nv_shadow_sram_tb.sv
module nv_shadow_sram_tb;
  localparam int DEPTH      = 2048;
  localparam int STORE_CYC  = 20;
  localparam int RECALL_CYC = 8;
  localparam logic [12:0] K_STORE  = 13'h0FC0;
  localparam logic [12:0] K_RECALL = 13'h0C63;
  localparam logic [12:0] KEYS [5] = '{13'h0E38, 13'h11C7, 13'h03E0, 13'h1C1F, 13'h103F};

  // {isWrite, addr, data}
  localparam int NVEC = 12;
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 13'h0010, 8'hA5}, {1'b1, 13'h0011, 8'h3C}, {1'b0, 13'h0010, 8'hA5},
    {1'b0, 13'h0011, 8'h3C}, {1'b1, 13'h0805, 8'h5A}, {1'b0, 13'h0005, 8'h5A},
    {1'b0, 13'h1805, 8'h5A}, {1'b1, 13'h07FF, 8'hFF}, {1'b1, 13'h0000, 8'h00},
    {1'b0, 13'h07FF, 8'hFF}, {1'b0, 13'h0000, 8'h00}, {1'b0, 13'h0010, 8'hA5}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  dqIn = '0;
  logic [7:0]  dqOut;
  logic        dqOutEn, busy;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  nv_shadow_sram #(.DEPTH(DEPTH), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .dqIn(dqIn), .dqOut(dqOut), .dqOutEn(dqOutEn), .busy(busy));

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; addr = a; dqIn = d;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic doRead(input logic [12:0] a, input logic oe, output logic [7:0] d, output logic en);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b1; oeN = oe; addr = a;
    @(negedge clk);
    d = dqOut; en = dqOutEn;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // brk: 0 none, 1 write inserted, 2 wrong read inserted, 3 ce-high pause
  task automatic runSeq(input logic [12:0] last, input int brkAt, input int brk);
    logic [7:0] d;
    logic en;
    for (int i = 0; i < 6; i++) begin
      if (i == brkAt) begin
        if (brk == 1) doWrite(13'h0200, 8'h55);
        else if (brk == 2) doRead(13'h0123, 1'b0, d, en);
        else if (brk == 3) begin
          @(negedge clk);
          weN = 1'b0; addr = 13'h0300; dqIn = 8'h77;
          repeat (4) @(negedge clk);
          weN = 1'b1;
        end
      end
      doRead((i < 5) ? KEYS[i] : last, 1'b0, d, en);
    end
  endtask

  task automatic expectRead(input string tag, input logic [12:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic en;
    doRead(a, 1'b0, d, en);
    check(tag, int'(en), 1);
    check(tag, int'(d), int'(exp));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] d;
    logic en;

    repeat (3) @(negedge clk);
    check("R2 reset bus off", int'(dqOutEn), 0);
    rstN = 1'b1;
    #1;
    waitIdle(n);
    check("R2 power-up recall length", n, RECALL_CYC);

    // R1 table of plain reads and writes
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][21]) doWrite(VEC[v][20:8], VEC[v][7:0]);
      else expectRead("R1 vector", VEC[v][20:8], VEC[v][7:0]);
    end

    // R9 read with oeN high
    doRead(13'h0010, 1'b1, d, en);
    check("R9 oe high", int'(en), 0);

    // R3 clean store
    doWrite(13'h0100, 8'h11);
    doWrite(13'h07FF, 8'hEE);
    runSeq(K_STORE, -1, 0);
    waitIdle(n);
    check("R3 store length", n, STORE_CYC);

    // R7 access while busy
    runSeq(K_STORE, -1, 0);
    check("R7 busy after store key", int'(busy), 1);
    doWrite(13'h0100, 8'h99);
    doRead(13'h0100, 1'b0, d, en);
    check("R7 bus off while busy", int'(en), 0);
    waitIdle(n);
    expectRead("R7 write ignored", 13'h0100, 8'h11);

    // R4 recall discards later writes
    doWrite(13'h0100, 8'h22);
    expectRead("R1 overwrite", 13'h0100, 8'h22);
    runSeq(K_RECALL, -1, 0);
    waitIdle(n);
    check("R4 recall length", n, RECALL_CYC);
    expectRead("R4 restored word", 13'h0100, 8'h11);
    expectRead("R4 restored top word", 13'h07FF, 8'hEE);

    // R8 write then repeated recall
    doWrite(13'h0100, 8'h33);
    runSeq(K_RECALL, -1, 0);
    waitIdle(n);
    expectRead("R8 shadow untouched by write", 13'h0100, 8'h11);
    runSeq(K_RECALL, -1, 0);
    waitIdle(n);
    expectRead("R8 repeated recall", 13'h0100, 8'h11);

    // R5 abort by write
    doWrite(13'h0100, 8'h44);
    runSeq(K_STORE, 3, 1);
    check("R5 write abort no busy", int'(busy), 0);
    // R5 abort by wrong read
    runSeq(K_STORE, 4, 2);
    check("R5 wrong read no busy", int'(busy), 0);
    runSeq(K_RECALL, -1, 0);
    waitIdle(n);
    expectRead("R5 no store happened", 13'h0100, 8'h11);

    // R6 ce-high pause inside run
    doWrite(13'h0300, 8'h01);
    doWrite(13'h0100, 8'h66);
    runSeq(K_STORE, 2, 3);
    check("R6 run survives pause", int'(busy), 1);
    waitIdle(n);
    check("R6 store length after pause", n, STORE_CYC);
    expectRead("R6 no write with ce high", 13'h0300, 8'h01);
    doWrite(13'h0100, 8'h00);
    runSeq(K_RECALL, -1, 0);
    waitIdle(n);
    expectRead("R6 store took effect", 13'h0100, 8'h66);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule